// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers 32 primary interrupt sources and 32 secondary sources into one interrupt line toward a processor. The secondary sources do not reach the primary directly. They are masked, split into three fixed groups, and each group is ORed into one summary bit of the primary status word. Most sources follow their input level. A fixed set of sources at each level is edge-sensitive: a rising edge sets a sticky latch bit, and that bit stays set until software clears it. Three primary bits can also be raised from a software-interrupt register.

Each cycle the controller resolves a 1-based vector for the winning source. The winner is the lowest-numbered pending primary bit. When that bit is a summary bit, the search moves to the secondary level. A small synchronous register port lets software read status, set the masks, clear latched edges and raise software interrupts.

Top module: `casc_intc`

## Requirements
- R1: After reset the primary mask, primary latch, software-interrupt, secondary latch and secondary mask registers all read 0. `irq_o` and `vec_valid_o` are low and `vec_o` is 0.
- R2: Level primary bits (all bits except 4–6, 16–19, 22–24 and 28–30) follow `pri_src_i`. A primary bit is pending only when its status bit and its primary mask bit (address 1) are both 1.
- R3: Primary bits 16–19, 22–24 and 28–30 set a latch bit on a rising input edge, and the bit holds after the input falls. Writing the latch register (address 2) clears each bit written as 0. A written 1 never sets a bit. Non-edge bit positions always read 0 at address 2.
- R4: If a rising edge and a clearing write to the same latch bit fall in the same cycle, the bit stays set. This holds for the primary latch and for the secondary latch.
- R5: The software-interrupt register (address 3) stores only bits 28–30 and reads 0 elsewhere. A set bit drives the primary status bit at the same position.
- R6: Primary status bit 6 is the OR of masked secondary bits 0–7. Bit 5 is the OR of masked secondary bits 8–15. Bit 4 is the OR of masked secondary bits 16–31. The `pri_src_i` pins at positions 4–6 have no effect.
- R7: Secondary bits 16, 22 and 28 latch on a rising edge. They are read and cleared through address 4, where a bit written as 0 clears. All other secondary bits follow `sec_src_i` at address 4. The secondary mask is at address 5.
- R8: When the lowest pending primary bit p is not 4, 5 or 6, `vec_o` is p+1. When it is one of those bits, `vec_o` is s+33, where s is the lowest pending (masked) secondary bit. `vec_valid_o` equals `irq_o`.
- R9: `irq_o`, `vec_valid_o` and `vec_o` are registered. They reflect status and masks one clock later. When nothing is pending, `vec_o` is 0 and `vec_valid_o` is low.
- R10: Address 0 returns primary status and is read-only. A read strobed in one cycle returns its data on `rdata_o` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_src_i | input | 32 | Primary interrupt inputs |
| sec_src_i | input | 32 | Secondary interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector is meaningful |
| vec_o | output | 7 | 1-based winning source number, 0 when idle |

## Verification
The bench builds the block with its default configuration: 32 primary bits, 32 secondary bits and a 3-bit address. At that size every source bit can be driven on its own. It sweeps each primary and each secondary source singly, and each edge bit through pulse, hold and clear. It then builds priority ladders by cutting the pending set off below each bit position and comparing the vector with the lowest set bit, which the bench computes itself. The mixed primary/secondary cases reach the cascade decision from both sides of the summary bits.

// File: rtl/casc_intc_pkg.sv
package casc_intc_pkg;

    localparam int NSRC   = 32;
    localparam int REG_AW = 3;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int VEC_W  = $clog2(2 * NSRC + 1);

    // Edge-sensitive source positions
    localparam logic [NSRC-1:0] PRI_EDGE = 32'h71CF_0000;
    localparam logic [NSRC-1:0] SEC_EDGE = 32'h1041_0000;
    localparam logic [NSRC-1:0] SWI_BITS = 32'h7000_0000;

    // Secondary groups and the primary summary bit each one feeds
    localparam logic [NSRC-1:0] GRP_LOW  = 32'h0000_00FF;
    localparam logic [NSRC-1:0] GRP_MID  = 32'h0000_FF00;
    localparam logic [NSRC-1:0] GRP_HIGH = 32'hFFFF_0000;
    localparam int SUM_LOW  = 6;
    localparam int SUM_MID  = 5;
    localparam int SUM_HIGH = 4;

    localparam logic [REG_AW-1:0] A_PSTAT  = 3'd0;
    localparam logic [REG_AW-1:0] A_PMASK  = 3'd1;
    localparam logic [REG_AW-1:0] A_PLATCH = 3'd2;
    localparam logic [REG_AW-1:0] A_SWI    = 3'd3;
    localparam logic [REG_AW-1:0] A_SSTAT  = 3'd4;
    localparam logic [REG_AW-1:0] A_SMASK  = 3'd5;

    typedef struct packed {
        logic              valid;
        logic [VEC_W-1:0]  num;
    } vec_t;

    function automatic logic is_summary(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(SUM_LOW)) || (idx == IDX_W'(SUM_MID)) ||
               (idx == IDX_W'(SUM_HIGH));
    endfunction

endpackage

// File: rtl/casc_edge_bank.sv
module casc_edge_bank #(
    parameter int           W         = 32,
    parameter logic [W-1:0] EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_keep_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] latch_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            logic held_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    held_q <= 1'b0;
                end else begin
                    prev_q <= level_i[i];
                    if (level_i[i] && !prev_q)
                        held_q <= 1'b1;
                    else if (clr_we_i && !clr_keep_i[i])
                        held_q <= 1'b0;
                end
            end
            assign status_o[i] = held_q;
            assign latch_o[i]  = held_q;
        end else begin : g_level
            assign status_o[i] = level_i[i];
            assign latch_o[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/casc_ffs.sv
module casc_ffs #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          found_o
);
    always_comb begin
        idx_o   = '0;
        found_o = |vec_i;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = i[IW-1:0];
        end
    end
endmodule

// File: rtl/casc_intc.sv
module casc_intc
    import casc_intc_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  pri_src_i,
    input  logic [NSRC-1:0]  sec_src_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [NSRC-1:0]  wdata_i,
    output logic [NSRC-1:0]  rdata_o,
    output logic             irq_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o
);
    logic [NSRC-1:0] pmask, smask, swi;
    logic [NSRC-1:0] sstat, slatch, smasked;
    logic [NSRC-1:0] plevel, pstat_raw, platch, pstat, ppend;
    logic [IDX_W-1:0] pidx, sidx;
    logic             pfound, sfound;
    vec_t             vec_d, vec_q;

    wire pwr_latch = wr_en_i && (addr_i == A_PLATCH);
    wire swr_latch = wr_en_i && (addr_i == A_SSTAT);

    // Secondary level
    casc_edge_bank #(.W(NSRC), .EDGE_MASK(SEC_EDGE)) u_sec (
        .clk(clk), .rst(rst), .level_i(sec_src_i),
        .clr_we_i(swr_latch), .clr_keep_i(wdata_i),
        .status_o(sstat), .latch_o(slatch)
    );
    assign smasked = sstat & smask;

    // Primary inputs with the three cascade summaries spliced in
    always_comb begin
        plevel           = pri_src_i;
        plevel[SUM_LOW]  = |(smasked & GRP_LOW);
        plevel[SUM_MID]  = |(smasked & GRP_MID);
        plevel[SUM_HIGH] = |(smasked & GRP_HIGH);
    end

    casc_edge_bank #(.W(NSRC), .EDGE_MASK(PRI_EDGE)) u_pri (
        .clk(clk), .rst(rst), .level_i(plevel),
        .clr_we_i(pwr_latch), .clr_keep_i(wdata_i),
        .status_o(pstat_raw), .latch_o(platch)
    );
    assign pstat = pstat_raw | (swi & SWI_BITS);
    assign ppend = pstat & pmask;

    casc_ffs #(.W(NSRC)) u_pri_ffs (.vec_i(ppend),   .idx_o(pidx), .found_o(pfound));
    casc_ffs #(.W(NSRC)) u_sec_ffs (.vec_i(smasked), .idx_o(sidx), .found_o(sfound));

    always_comb begin
        vec_d = '0;
        if (pfound) begin
            vec_d.valid = 1'b1;
            if (is_summary(pidx) && sfound)
                vec_d.num = VEC_W'(sidx) + VEC_W'(NSRC + 1);
            else
                vec_d.num = VEC_W'(pidx) + VEC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            irq_o <= 1'b0;
        end else begin
            vec_q <= vec_d;
            irq_o <= |ppend;
        end
    end
    assign vec_valid_o = vec_q.valid;
    assign vec_o       = vec_q.num;

    // Register port
    always_ff @(posedge clk) begin
        if (rst) begin
            pmask   <= '0;
            smask   <= '0;
            swi     <= '0;
            rdata_o <= '0;
        end else begin
            if (wr_en_i) begin
                case (addr_i)
                    A_PMASK: pmask <= wdata_i;
                    A_SWI:   swi   <= wdata_i & SWI_BITS;
                    A_SMASK: smask <= wdata_i;
                    default: ;
                endcase
            end
            if (rd_en_i) begin
                case (addr_i)
                    A_PSTAT:  rdata_o <= pstat;
                    A_PMASK:  rdata_o <= pmask;
                    A_PLATCH: rdata_o <= platch;
                    A_SWI:    rdata_o <= swi;
                    A_SSTAT:  rdata_o <= sstat;
                    A_SMASK:  rdata_o <= smask;
                    default:  rdata_o <= '0;
                endcase
            end
        end
    end

    wire unused_ok = ^slatch;
endmodule

// File: rtl/casc_intc_chk.sv
module casc_intc_chk
    import casc_intc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq_o,
    input logic             vec_valid_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [NSRC-1:0]  ppend,
    input logic [NSRC-1:0]  platch,
    input logic             wr_en,
    input logic [REG_AW-1:0] addr
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq_o && !vec_valid_o && vec_o == '0));

    assert_irq_delay_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_o == $past(|ppend)));

    assert_valid_match_R8: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o == irq_o);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !vec_valid_o |-> (vec_o == '0));

    assert_vec_range_R8: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> (vec_o >= VEC_W'(1) && vec_o <= VEC_W'(2 * NSRC)));

    assert_latch_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(wr_en) && $past(addr) == A_PLATCH))
            |-> ((platch & $past(platch)) == $past(platch)));
endmodule

bind casc_intc casc_intc_chk u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .vec_valid_o(vec_valid_o),
    .vec_o(vec_o), .ppend(ppend), .platch(platch),
    .wr_en(wr_en_i), .addr(addr_i)
);

// File: tb/sim_casc_intc.sv
module sim_casc_intc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pri = '0, sec = '0, wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] rdata;
    logic        irq, vvalid;
    logic [6:0]  vec;
    int          checks = 0, fails = 0;
    logic        done = 1'b0;

    localparam logic [31:0] PEDGE = 32'h71CF_0000;
    localparam logic [31:0] SEDGE = 32'h1041_0000;
    localparam logic [31:0] PLVL  = ~PEDGE & ~32'h0000_0070;

    always #4 clk = ~clk;

    casc_intc u0 (
        .clk(clk), .rst(rst), .pri_src_i(pri), .sec_src_i(sec),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .vec_valid_o(vvalid), .vec_o(vec)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic expect_vec(input string req, input int exp);
        chk(req, "irq", {31'b0, irq}, 32'(exp != 0));
        chk(req, "valid", {31'b0, vvalid}, 32'(exp != 0));
        chk(req, "vector", {25'b0, vec}, 32'(exp));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_vec("R1", 0);
        for (int a = 1; a <= 5; a++) begin
            rd(3'(a), d);
            chk("R1", "reg after reset", d, 32'h0);
        end

        // R10 mask readback, R2 level sweep
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d);
        chk("R10", "pmask readback", d, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d);
        chk("R10", "pstat read-only", d, 32'h0);
        for (int i = 0; i < 32; i++) begin
            if (PLVL[i]) begin
                @(negedge clk); pri = 32'h1 << i;
                settle();
                expect_vec("R2", i + 1);
                @(negedge clk); pri = '0;
                settle();
                expect_vec("R2", 0);
            end
        end

        // R8 priority ladder
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); pri = PLVL & ~((32'h1 << i) - 32'h1);
            settle();
            if (pri != 0) expect_vec("R8", lowest(pri) + 1);
        end
        @(negedge clk); pri = '0;

        // R2 mask gating
        wr(3'd1, ~32'h8);
        @(negedge clk); pri = 32'h8;
        settle();
        expect_vec("R2", 0);
        @(negedge clk); pri = 32'h208;
        settle();
        expect_vec("R2", 10);
        @(negedge clk); pri = '0;
        wr(3'd1, 32'hFFFF_FFFF);

        // R6 summary pins ignored
        @(negedge clk); pri = 32'h70;
        settle();
        expect_vec("R6", 0);
        rd(3'd0, d);
        chk("R6", "pins 4-6 ignored", d & 32'h70, 32'h0);
        @(negedge clk); pri = '0;

        // R3 primary edge sweep
        for (int i = 0; i < 32; i++) begin
            if (PEDGE[i]) begin
                @(negedge clk); pri = 32'h1 << i;
                @(negedge clk); pri = '0;
                settle();
                expect_vec("R3", i + 1);
                rd(3'd2, d);
                chk("R3", "latch held", d, 32'h1 << i);
                wr(3'd2, ~(32'h1 << i));
                settle();
                expect_vec("R3", 0);
            end
        end
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d);
        chk("R3", "write ones sets nothing", d, 32'h0);

        // R4 edge wins over clear, primary
        @(negedge clk);
        pri = 32'h0002_0000; wr_en = 1'b1; addr = 3'd2; wdata = 32'h0;
        @(negedge clk);
        wr_en = 1'b0; pri = '0;
        rd(3'd2, d);
        chk("R4", "primary edge beats clear", d, 32'h0002_0000);
        wr(3'd2, 32'h0);
        settle();

        // R5 software interrupts
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d);
        chk("R5", "swi storage", d, 32'h7000_0000);
        settle();
        expect_vec("R5", 29);
        wr(3'd3, 32'h4000_0000);
        settle();
        expect_vec("R5", 31);
        wr(3'd3, 32'h0);
        settle();
        expect_vec("R5", 0);

        // R6 / R8 secondary level sweep
        wr(3'd5, 32'hFFFF_FFFF);
        for (int s = 0; s < 32; s++) begin
            if (!SEDGE[s]) begin
                @(negedge clk); sec = 32'h1 << s;
                settle();
                expect_vec("R8", s + 33);
                rd(3'd0, d);
                chk("R6", "summary bit", d & 32'h70,
                    (s < 8) ? 32'h40 : (s < 16) ? 32'h20 : 32'h10);
                @(negedge clk); sec = '0;
                settle();
                expect_vec("R7", 0);
            end
        end

        // R7 secondary edge sweep
        for (int s = 0; s < 32; s++) begin
            if (SEDGE[s]) begin
                @(negedge clk); sec = 32'h1 << s;
                @(negedge clk); sec = '0;
                settle();
                expect_vec("R7", s + 33);
                rd(3'd4, d);
                chk("R7", "secondary latch", d, 32'h1 << s);
                wr(3'd4, ~(32'h1 << s));
                settle();
                expect_vec("R7", 0);
            end
        end

        // R4 edge wins over clear, secondary
        @(negedge clk);
        sec = 32'h0040_0000; wr_en = 1'b1; addr = 3'd4; wdata = 32'h0;
        @(negedge clk);
        wr_en = 1'b0; sec = '0;
        rd(3'd4, d);
        chk("R4", "secondary edge beats clear", d, 32'h0040_0000);
        wr(3'd4, 32'h0);

        // R6 secondary mask
        wr(3'd5, ~32'h8);
        @(negedge clk); sec = 32'h8;
        settle();
        expect_vec("R6", 0);
        @(negedge clk); sec = '0;
        wr(3'd5, 32'hFFFF_FFFF);

        // R8 cascade ordering
        @(negedge clk); pri = 32'h4; sec = 32'h0010_0000;
        settle();
        expect_vec("R8", 3);
        @(negedge clk); pri = 32'h400;
        settle();
        expect_vec("R8", 53);
        @(negedge clk); sec = 32'h0010_0200;
        settle();
        expect_vec("R8", 42);
        wr(3'd1, ~32'h70);
        settle();
        expect_vec("R8", 11);
        @(negedge clk); pri = '0; sec = '0;
        wr(3'd1, 32'hFFFF_FFFF);

        // R9 one-cycle latency
        @(negedge clk); pri = 32'h1;
        @(negedge clk);
        chk("R9", "irq after one edge", {31'b0, irq}, 32'h1);
        @(negedge clk); pri = '0;
        @(negedge clk);
        expect_vec("R9", 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule